// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous DRAM array refreshed while a separate access controller runs normal reads and writes. A free-running interval timer adds one unit of refresh debt each period. The access controller sees the debt and lets refreshes through at convenient moments. When the debt reaches its limit, the request becomes mandatory. The scheduler then takes the memory pins as soon as the controller reports that no access is in progress, whether or not it has granted the pins.

Each refresh is one complete strobe sequence that the block drives itself. The default kind is an address-free refresh, in which the column strobe falls before the row strobe and the memory supplies the row from its own counter. The alternative kind, chosen per refresh by a mode input, presents a row address and then pulses only the row strobe. In that mode an internal row counter steps through all rows. The write strobe is held high throughout, so the memory never sees the pattern that selects its test mode. All strobes are active low. The timing of every phase is given in clock cycles by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset the debt is 0. With no refresh completing, the debt rises by one on every INTERVAL-th clock edge after reset. The timer keeps running and is not affected by refresh activity.
- R2: The debt never exceeds DEBT_MAX. A period that ends while the debt is at DEBT_MAX is lost. `rfs_req` is 1 exactly when the debt is nonzero, and `rfs_urgent` is 1 exactly when the debt equals DEBT_MAX.
- R3: A refresh starts at a clock edge only when the block is idle, the debt is nonzero, and either `rfs_gnt` is 1 or (`rfs_urgent` is 1 and `host_busy` is 0). `rfs_active` is 1 from the cycle after that edge until the refresh ends. Otherwise the block stays idle with `ras_n`=`cas_n`=1 and `mem_addr`=0.
- R4: A refresh opens with one cycle in which both strobes are high. Next come T_CSR cycles of setup with `ras_n` high. In address-free mode (`mode_row_addr`=0), `cas_n` is low through the setup and through the first T_CHR cycles in which `ras_n` is low, so `cas_n` falls strictly before `ras_n`.
- R5: `ras_n` is then low for T_RAS cycles, followed by T_RP cycles with both strobes high. On the last precharge edge the block returns to idle and the debt falls by one. If a timer period ends on that same edge, the debt stays unchanged.
- R6: `we_n` is 1 in every cycle, including around every fall of `ras_n`.
- R7: In row-address mode (`mode_row_addr`=1), `cas_n` stays high for the whole refresh. `mem_addr` shows the row counter from the opening cycle to the end of precharge. In address-free mode `mem_addr` is 0.
- R8: The row counter is 0 after reset. It advances by one at the end of each row-address refresh and wraps from ROWS-1 (2047 by default) to 0. Address-free refreshes leave it unchanged.
- R9: `mode_row_addr` is sampled only on the edge where a refresh starts. A change while a refresh is running does not affect that refresh's strobes or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_row_addr | input | 1 | 1 selects row-address refresh, 0 selects address-free refresh |
| host_busy | input | 1 | Access controller has an access in progress |
| rfs_gnt | input | 1 | Access controller offers the memory pins to the scheduler |
| rfs_req | output | 1 | Refresh debt is nonzero |
| rfs_urgent | output | 1 | Refresh debt is at its limit |
| rfs_debt | output | $clog2(DEBT_MAX+1) | Current refresh debt |
| rfs_active | output | 1 | Scheduler owns the memory pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| mem_addr | output | $clog2(ROWS) | Row address in row-address mode, otherwise 0 |

## Verification
A cycle-level model in the bench predicts every output from the same inputs. The first stimulus is random grants, busy flags and mode bits, changing every cycle. Mode changes in the middle of a refresh show whether the mode is latched at the start (R9), and sparse grants show whether debt builds and drains correctly. A directed stretch with no grant and the host busy drives the debt to saturation, then releases the host, which separates a mandatory start from a granted one. A long run of back-to-back row-address refreshes walks the row counter through its wrap. At every fall of `ras_n` in that mode, the address is compared with the count of such refreshes seen so far.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_GAP   = 3'd1,
      PH_SETUP = 3'd2,
      PH_ACT   = 3'd3,
      PH_PRE   = 3'd4
   } rfs_phase_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = $clog2(INTERVAL);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
   parameter int DEBT_MAX = 8,
   parameter int DW       = $clog2(DEBT_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          done,
   output logic [DW-1:0] debt,
   output logic          req,
   output logic          urgent
);
   generate
      if (DEBT_MAX < 1) begin : g_bad_max
         $error("DEBT_MAX must be at least 1");
      end
   endgenerate

   localparam logic [DW-1:0] LIMIT = DW'(DEBT_MAX);

   logic [DW-1:0] debt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt_q <= '0;
      end else if (tick && !done) begin
         if (debt_q != LIMIT) begin
            debt_q <= debt_q + 1'b1;
         end
      end else if (done && !tick) begin
         debt_q <= debt_q - 1'b1;
      end
   end

   assign debt   = debt_q;
   assign req    = (debt_q != '0);
   assign urgent = (debt_q == LIMIT);

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt_q <= LIMIT);

   // R5
   done_has_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> debt_q != '0);

   // R1
   debt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !done && debt_q != LIMIT) |=> debt_q == $past(debt_q) + 1'b1);
endmodule

// File: rtl/rfs_pin_seq.sv
module rfs_pin_seq
   import dram_rfs_pkg::*;
#(
   parameter int ROWS  = 2048,
   parameter int T_CSR = 1,
   parameter int T_CHR = 1,
   parameter int T_RAS = 3,
   parameter int T_RP  = 2,
   parameter int RW    = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ro_mode,
   output logic          active,
   output logic          done,
   output logic          ras_n,
   output logic          cas_n,
   output logic          we_n,
   output logic [RW-1:0] addr
);
   localparam int TMAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                        : ((T_RP  > T_CSR) ? T_RP  : T_CSR);
   localparam int PCW  = $clog2(TMAX + 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   generate
      if (T_CSR < 1 || T_CHR < 1 || T_RP < 1) begin : g_bad_phase
         $error("strobe phases must last at least one cycle");
      end
      if (T_CHR >= T_RAS) begin : g_bad_hold
         $error("T_CHR must be shorter than T_RAS");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
   endgenerate

   rfs_phase_e     ph_q;
   logic [PCW-1:0] pcnt_q;
   logic           ro_q;
   logic [RW-1:0]  row_q;
   logic [RW-1:0]  row_nxt;

   generate
      if (ROWS == (1 << RW)) begin : g_row_pow2
         assign row_nxt = row_q + 1'b1;
      end else begin : g_row_cmp
         assign row_nxt = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end
   endgenerate

   assign done = (ph_q == PH_PRE) && (pcnt_q == PCW'(T_RP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         pcnt_q <= '0;
         ro_q   <= 1'b0;
         row_q  <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q   <= PH_GAP;
                  pcnt_q <= '0;
                  ro_q   <= ro_mode;
               end
            end
            PH_GAP: begin
               ph_q   <= PH_SETUP;
               pcnt_q <= '0;
            end
            PH_SETUP: begin
               if (pcnt_q == PCW'(T_CSR - 1)) begin
                  ph_q   <= PH_ACT;
                  pcnt_q <= '0;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            PH_ACT: begin
               if (pcnt_q == PCW'(T_RAS - 1)) begin
                  ph_q   <= PH_PRE;
                  pcnt_q <= '0;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            PH_PRE: begin
               if (done) begin
                  ph_q   <= PH_IDLE;
                  pcnt_q <= '0;
                  if (ro_q) begin
                     row_q <= row_nxt;
                  end
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            default: begin
               ph_q   <= PH_IDLE;
               pcnt_q <= '0;
            end
         endcase
      end
   end

   logic cas_lo;
   always_comb begin
      cas_lo = 1'b0;
      if (!ro_q) begin
         if (ph_q == PH_SETUP) begin
            cas_lo = 1'b1;
         end else if (ph_q == PH_ACT && pcnt_q < PCW'(T_CHR)) begin
            cas_lo = 1'b1;
         end
      end
   end

   assign active = (ph_q != PH_IDLE);
   assign ras_n  = (ph_q != PH_ACT);
   assign cas_n  = !cas_lo;
   assign we_n   = 1'b1;
   assign addr   = (active && ro_q) ? row_q : '0;

   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !ro_q) |-> (!cas_n && !$past(cas_n)));

   // R7
   ro_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ro_q) |-> cas_n);

   // R8
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ro_q) |=> row_q == (($past(row_q) == ROW_LAST) ? '0 : $past(row_q) + 1'b1));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(ro_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int INTERVAL = 780,
   parameter int DEBT_MAX = 8,
   parameter int ROWS     = 2048,
   parameter int T_CSR    = 1,
   parameter int T_CHR    = 1,
   parameter int T_RAS    = 3,
   parameter int T_RP     = 2,
   parameter int DW       = $clog2(DEBT_MAX + 1),
   parameter int RW       = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_row_addr,
   input  logic          host_busy,
   input  logic          rfs_gnt,
   output logic          rfs_req,
   output logic          rfs_urgent,
   output logic [DW-1:0] rfs_debt,
   output logic          rfs_active,
   output logic          ras_n,
   output logic          cas_n,
   output logic          we_n,
   output logic [RW-1:0] mem_addr
);
   logic tick;
   logic done;
   logic start;

   rfs_interval_timer #(.INTERVAL(INTERVAL)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfs_debt_counter #(.DEBT_MAX(DEBT_MAX), .DW(DW)) i_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .done   (done),
      .debt   (rfs_debt),
      .req    (rfs_req),
      .urgent (rfs_urgent)
   );

   assign start = !rfs_active && rfs_req && (rfs_gnt || (rfs_urgent && !host_busy));

   rfs_pin_seq #(
      .ROWS(ROWS), .T_CSR(T_CSR), .T_CHR(T_CHR),
      .T_RAS(T_RAS), .T_RP(T_RP), .RW(RW)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ro_mode (mode_row_addr),
      .active  (rfs_active),
      .done    (done),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .addr    (mem_addr)
   );

   // R3
   urgent_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfs_urgent && !host_busy && !rfs_active) |=> rfs_active);

   // R3
   start_needs_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rfs_active) |-> $past(rfs_req));

   // R6
   we_at_ras_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (we_n && $past(we_n)));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
   localparam int INTERVAL = 10;
   localparam int DEBT_MAX = 8;
   localparam int ROWS     = 2048;
   localparam int T_CSR    = 1;
   localparam int T_CHR    = 1;
   localparam int T_RAS    = 3;
   localparam int T_RP     = 2;
   localparam int DW       = $clog2(DEBT_MAX + 1);
   localparam int RW       = $clog2(ROWS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_row_addr = 1'b0;
   logic host_busy = 1'b0;
   logic rfs_gnt = 1'b0;
   logic rfs_req, rfs_urgent, rfs_active, ras_n, cas_n, we_n;
   logic [DW-1:0] rfs_debt;
   logic [RW-1:0] mem_addr;

   always #10 clk = ~clk;

   dram_refresh_sched #(
      .INTERVAL(INTERVAL), .DEBT_MAX(DEBT_MAX), .ROWS(ROWS),
      .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
   ) i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .mode_row_addr(mode_row_addr),
      .host_busy(host_busy), .rfs_gnt(rfs_gnt), .rfs_req(rfs_req),
      .rfs_urgent(rfs_urgent), .rfs_debt(rfs_debt), .rfs_active(rfs_active),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // bench model: phase 0 idle, 1 gap, 2 setup, 3 ras low, 4 precharge
   int m_tcnt, m_debt, m_ph, m_pcnt, m_row;
   bit m_ro;
   bit m_tick, m_done, m_start;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_tcnt = 0; m_debt = 0; m_ph = 0; m_pcnt = 0; m_row = 0; m_ro = 0;
      end else begin
         m_tick  = (m_tcnt == INTERVAL - 1);
         m_done  = (m_ph == 4) && (m_pcnt == T_RP - 1);
         m_start = (m_ph == 0) && (m_debt != 0) &&
                   (rfs_gnt || (m_debt == DEBT_MAX && !host_busy));
         m_tcnt  = m_tick ? 0 : m_tcnt + 1;
         if (m_tick && !m_done && m_debt < DEBT_MAX) m_debt++;
         else if (m_done && !m_tick) m_debt--;
         case (m_ph)
            0: if (m_start) begin m_ph = 1; m_pcnt = 0; m_ro = mode_row_addr; end
            1: begin m_ph = 2; m_pcnt = 0; end
            2: if (m_pcnt == T_CSR - 1) begin m_ph = 3; m_pcnt = 0; end else m_pcnt++;
            3: if (m_pcnt == T_RAS - 1) begin m_ph = 4; m_pcnt = 0; end else m_pcnt++;
            default: if (m_done) begin
                  m_ph = 0; m_pcnt = 0;
                  if (m_ro) m_row = (m_row + 1) % ROWS;
               end else m_pcnt++;
         endcase
      end
   end

   function automatic int exp_cas();
      if (m_ro) return 1;
      if (m_ph == 2) return 0;
      if (m_ph == 3 && m_pcnt < T_CHR) return 0;
      return 1;
   endfunction

   task automatic cmp(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   int ro_falls = 0;
   logic prev_ras = 1'b1;

   task automatic check_all();
      cmp("R5 ras_n", int'(ras_n), (m_ph == 3) ? 0 : 1);
      cmp("R4 cas_n", int'(cas_n), exp_cas());
      cmp("R6 we_n", int'(we_n), 1);
      cmp("R7 mem_addr", int'(mem_addr), (m_ph != 0 && m_ro) ? m_row : 0);
      cmp("R1 rfs_debt", int'(rfs_debt), m_debt);
      cmp("R2 rfs_req", int'(rfs_req), (m_debt != 0) ? 1 : 0);
      cmp("R2 rfs_urgent", int'(rfs_urgent), (m_debt == DEBT_MAX) ? 1 : 0);
      cmp("R3 rfs_active", int'(rfs_active), (m_ph != 0) ? 1 : 0);
      if (prev_ras && !ras_n && m_ro) begin
         // R8: address at each row-address refresh equals count of earlier ones mod ROWS
         cmp("R8 row at ras fall", int'(mem_addr), ro_falls % ROWS);
         ro_falls++;
      end
      prev_ras = ras_n;
   endtask

   task automatic step();
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 R3: reset state
      cmp("R1 reset debt", int'(rfs_debt), 0);
      cmp("R3 reset ras_n", int'(ras_n), 1);
      cmp("R8 reset addr", int'(mem_addr), 0);

      // random grants, busy and mode (R9 mode toggles mid-refresh)
      for (int i = 0; i < 3000; i++) begin
         rfs_gnt       = ($urandom % 4) == 0;
         host_busy     = $urandom % 2;
         mode_row_addr = $urandom % 2;
         step();
      end

      // directed: starve until saturation (R2)
      rfs_gnt = 1'b0; host_busy = 1'b1;
      while (rfs_active) step();
      repeat (INTERVAL * (DEBT_MAX + 2)) step();
      cmp("R2 saturated debt", int'(rfs_debt), DEBT_MAX);
      cmp("R2 urgent at limit", int'(rfs_urgent), 1);
      cmp("R3 no start while busy", int'(rfs_active), 0);
      // release host: mandatory start without grant (R3)
      mode_row_addr = 1'b0;
      host_busy = 1'b0;
      step();
      step();
      cmp("R3 urgent start", int'(rfs_active), 1);
      repeat (200) step();

      // back-to-back row-address refreshes through the wrap (R8)
      mode_row_addr = 1'b1; rfs_gnt = 1'b1;
      repeat (INTERVAL * (ROWS + 40)) step();
      cmp("R8 wrap passed", (ro_falls > ROWS) ? 1 : 0, 1);
      finish_run();
   end
endmodule